// File: doc/BRIEF.md
# Indexed Offset Data-Memory Execution Unit

This unit carries out three one-word operations whose operand sits in data memory. The operand's address is a 12-bit pointer plus an unsigned literal offset taken from the low byte of the instruction word. The first operation adds the accumulator to the addressed byte and places the sum in the accumulator or in memory. The second sets one chosen bit of the addressed byte. The third fills the addressed byte with all ones. The data path is 8 bits wide. Only the add operation changes the five status flags.

Every instruction runs in four phases: decode, read, process and write. A phase strobe from the surrounding core moves the unit from one phase to the next. The strobe may stay low for any number of clocks between phases, and the unit holds its phase during that time. The unit drives a synchronous single-port data memory. A read request in the read phase returns its data on the following clock. That data is captured when the process strobe arrives. Any memory write happens on the write strobe.

An offset above 95 is reported as an illegal instruction. Such an instruction, and any word that is not one of the three encodings, leaves memory, accumulator and flags as they were.

Top module: `idx_exec_unit`

## Requirements
- R1: While `rst_n` is low and after it rises, the accumulator is 00h, the flags are 0, `phase` is 0 (decode) and neither memory enable is asserted.
- R2: Each clock with `phase_strobe` high moves `phase` on one step: 0 decode, 1 read, 2 process, 3 write, then back to 0. A clock with the strobe low leaves `phase` unchanged.
- R3: The memory address of an executed instruction is (pointer + offset) modulo 4096, so 0FFFh + 5Fh gives 05Eh. The pointer and the instruction word are sampled on the decode strobe.
- R4: The word 0010 01d0 kkkk kkkk (bits 15..0) adds the accumulator to memory[ea] modulo 256. When d (bit 9) is 0 the sum goes to the accumulator. When d is 1 the sum is written back to memory[ea].
- R5: After an add, `flags` holds {N, OV, Z, DC, C} in bits 4..0. N is result bit 7. OV is signed overflow. Z marks a zero result. DC is the carry out of bit 3. C is the carry out of bit 7.
- R6: The word 1000 bbb0 kkkk kkkk sets bit b (bits 11..9) of memory[ea] and keeps its other bits. The accumulator and flags do not change.
- R7: The word 0110 1000 kkkk kkkk writes FFh to memory[ea]. The accumulator and flags do not change.
- R8: If one of the three encodings carries an offset above 95, `illegal` goes high from its decode strobe until the next decode strobe. No memory read or write takes place, and the accumulator and flags stay unchanged.
- R9: Any other instruction word causes no memory access and changes nothing. It leaves `illegal` low.
- R10: `mem_rd_en` is high for exactly the clock of the read-phase strobe, and `mem_wr_en` for exactly the clock of the write-phase strobe. The two are never high together.
- R11: `mem_rdata` is sampled on the process-phase strobe, so any number of idle clocks between the read and process strobes gives the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_strobe | input | 1 | Advances the four-phase sequence |
| instr | input | 16 | Instruction word, sampled at the decode strobe |
| ptr | input | 12 | Pointer value, sampled at the decode strobe |
| mem_addr | output | 12 | Data-memory address |
| mem_rd_en | output | 1 | Read request; data returns the next clock |
| mem_rdata | input | 8 | Read data from memory |
| mem_wr_en | output | 1 | Write enable |
| mem_wdata | output | 8 | Write data |
| acc | output | 8 | Accumulator |
| flags | output | 5 | {N, OV, Z, DC, C} |
| illegal | output | 1 | Offset-out-of-range indication |
| phase | output | 2 | Current phase, 0 to 3 |

## Verification
The hardest case to reach is an add with a chosen accumulator value against a chosen memory byte. The ports give no way to load the accumulator directly. The bench therefore places, at a scratch address, the difference between the wanted value and the value it currently models. It then runs a d=0 add on that byte before each test add. This gives a near-full grid of operand pairs, including the corners around 7Fh, 80h, 0Fh and FFh. Strobe gaps between phases are swept at the same time, so the sampling point for read data is also exercised.

// File: rtl/idx_pkg.sv
// Shared types for the indexed-offset execution unit.
// Assumes: a four-phase sequence and three supported operations.
package idx_pkg;
    typedef enum logic [1:0] {
        PH_DEC  = 2'd0,
        PH_RD   = 2'd1,
        PH_PROC = 2'd2,
        PH_WR   = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ADD  = 2'd1,
        OP_BSET = 2'd2,
        OP_FILL = 2'd3
    } op_e;

    localparam int FLAG_W = 5;
endpackage

// File: rtl/idx_decode.sv
// Instruction decoder: classifies the word, extracts the offset, the bit index
// and the destination select, and checks the offset against the legal limit.
// Assumes: the offset occupies the low KW bits of the word.
module idx_decode
    import idx_pkg::*;
#(
    parameter int IW    = 16,
    parameter int KW    = 8,
    parameter int BW    = 3,
    parameter int MAX_K = 95
) (
    input  logic [IW-1:0] instr,
    output op_e           op,
    output logic          to_mem,
    output logic [BW-1:0] bit_sel,
    output logic [KW-1:0] k,
    output logic          k_ok
);
    localparam int TOP = IW - 1;

    // Opcode match on the fixed upper bits.
    always_comb begin
        op = OP_NONE;
        if (instr[TOP -: 6] == 6'b001001 && !instr[TOP-7])
            op = OP_ADD;
        else if (instr[TOP -: 4] == 4'b1000 && !instr[TOP-7])
            op = OP_BSET;
        else if (instr[TOP -: 8] == 8'h68)
            op = OP_FILL;
    end

    // Field extraction and offset range check.
    assign to_mem  = instr[TOP-6];
    assign bit_sel = instr[TOP-4 -: BW];
    assign k       = instr[KW-1:0];
    assign k_ok    = (k <= KW'(MAX_K));
endmodule

// File: rtl/idx_agu.sv
// Address generator: adds the offset to the pointer and keeps the low AW
// bits, so any overflow wraps around.
// Assumes: AW >= KW.
module idx_agu #(
    parameter int AW = 12,
    parameter int KW = 8
) (
    input  logic [AW-1:0] ptr,
    input  logic [KW-1:0] k,
    output logic [AW-1:0] ea
);
    // Modular sum at the address width.
    assign ea = ptr + AW'(k);
endmodule

// File: rtl/idx_alu.sv
// Data ALU: computes the add result with its flags, the bit-set result, and
// the all-ones fill value.
// Assumes: DW is even; DC is the carry out of the lower half.
module idx_alu
    import idx_pkg::*;
#(
    parameter int DW = 8,
    parameter int BW = 3
) (
    input  op_e               op,
    input  logic [DW-1:0]     acc_in,
    input  logic [DW-1:0]     opnd,
    input  logic [BW-1:0]     bit_sel,
    output logic [DW-1:0]     res,
    output logic [FLAG_W-1:0] flg
);
    localparam int HW = DW / 2;

    logic [DW:0]   sum;
    logic [HW:0]   half;
    logic [DW-1:0] mask;

    // One-hot mask for the selected bit.
    for (genvar i = 0; i < DW; i++) begin : g_mask
        assign mask[i] = (bit_sel == BW'(i));
    end

    // Full and lower-half sums.
    assign sum  = {1'b0, acc_in} + {1'b0, opnd};
    assign half = {1'b0, acc_in[HW-1:0]} + {1'b0, opnd[HW-1:0]};

    // Result select per operation.
    always_comb begin
        unique case (op)
            OP_ADD:  res = sum[DW-1:0];
            OP_BSET: res = opnd | mask;
            OP_FILL: res = '1;
            default: res = opnd;
        endcase
    end

    // Flags {N, OV, Z, DC, C} for the add.
    always_comb begin
        flg[4] = sum[DW-1];
        flg[3] = (acc_in[DW-1] == opnd[DW-1]) && (sum[DW-1] != acc_in[DW-1]);
        flg[2] = (sum[DW-1:0] == '0);
        flg[1] = half[HW];
        flg[0] = sum[DW];
    end
endmodule

// File: rtl/idx_exec_unit.sv
// Top of the indexed-offset execution unit. A phase counter steps through
// decode, read, process and write on each strobe. Decode latches the operation
// and address, read requests the operand, process registers the ALU result,
// and write commits it to memory, accumulator and flags.
// Assumes: the memory returns read data one clock after mem_rd_en and holds it
// until the process strobe.
module idx_exec_unit
    import idx_pkg::*;
#(
    parameter int DW    = 8,
    parameter int AW    = 12,
    parameter int IW    = 16,
    parameter int KW    = 8,
    parameter int MAX_K = 95
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase_strobe,
    input  logic [IW-1:0]     instr,
    input  logic [AW-1:0]     ptr,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_rd_en,
    input  logic [DW-1:0]     mem_rdata,
    output logic              mem_wr_en,
    output logic [DW-1:0]     mem_wdata,
    output logic [DW-1:0]     acc,
    output logic [FLAG_W-1:0] flags,
    output logic              illegal,
    output logic [1:0]        phase
);
    localparam int BW = $clog2(DW);

    phase_e            ph_q;
    op_e               dec_op, op_q;
    logic              dec_to_mem, to_mem_q;
    logic [BW-1:0]     dec_bit, bit_q;
    logic [KW-1:0]     dec_k;
    logic              dec_k_ok;
    logic [AW-1:0]     dec_ea, ea_q;
    logic              ill_q;
    logic [DW-1:0]     alu_res, res_q, acc_q;
    logic [FLAG_W-1:0] alu_flg, flg_nxt_q, flags_q;
    logic              mem_dest;

    idx_decode #(.IW(IW), .KW(KW), .BW(BW), .MAX_K(MAX_K)) u_dec (
        .instr   (instr),
        .op      (dec_op),
        .to_mem  (dec_to_mem),
        .bit_sel (dec_bit),
        .k       (dec_k),
        .k_ok    (dec_k_ok)
    );

    idx_agu #(.AW(AW), .KW(KW)) u_agu (
        .ptr (ptr),
        .k   (dec_k),
        .ea  (dec_ea)
    );

    idx_alu #(.DW(DW), .BW(BW)) u_alu (
        .op      (op_q),
        .acc_in  (acc_q),
        .opnd    (mem_rdata),
        .bit_sel (bit_q),
        .res     (alu_res),
        .flg     (alu_flg)
    );

    // Phase counter: steps once per strobe and wraps after the write phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ph_q <= PH_DEC;
        else if (phase_strobe)
            ph_q <= phase_e'(2'(ph_q + 2'd1));
    end

    // Decode capture: latches the operation, fields, address and illegal flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_NONE;
            to_mem_q <= 1'b0;
            bit_q    <= '0;
            ea_q     <= '0;
            ill_q    <= 1'b0;
        end else if (phase_strobe && ph_q == PH_DEC) begin
            op_q     <= dec_k_ok ? dec_op : OP_NONE;
            to_mem_q <= dec_to_mem;
            bit_q    <= dec_bit;
            ea_q     <= dec_ea;
            ill_q    <= (dec_op != OP_NONE) && !dec_k_ok;
        end
    end

    // Process capture: registers the ALU result and the candidate flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q     <= '0;
            flg_nxt_q <= '0;
        end else if (phase_strobe && ph_q == PH_PROC) begin
            res_q     <= alu_res;
            flg_nxt_q <= alu_flg;
        end
    end

    // Write commit: updates the accumulator and flags for an add.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            flags_q <= '0;
        end else if (phase_strobe && ph_q == PH_WR && op_q == OP_ADD) begin
            flags_q <= flg_nxt_q;
            if (!to_mem_q)
                acc_q <= res_q;
        end
    end

    // Memory destination: bit-set and fill always, add only when d is set.
    always_comb begin
        unique case (op_q)
            OP_ADD:            mem_dest = to_mem_q;
            OP_BSET, OP_FILL:  mem_dest = 1'b1;
            default:           mem_dest = 1'b0;
        endcase
    end

    // Memory port drive.
    assign mem_addr  = ea_q;
    assign mem_rd_en = phase_strobe && (ph_q == PH_RD) && (op_q != OP_NONE);
    assign mem_wr_en = phase_strobe && (ph_q == PH_WR) && mem_dest;
    assign mem_wdata = res_q;

    // Architectural outputs.
    assign acc     = acc_q;
    assign flags   = flags_q;
    assign illegal = ill_q;
    assign phase   = ph_q;
endmodule

// File: rtl/idx_exec_chk.sv
// Protocol checker for idx_exec_unit, attached through bind.
// Assumes: the phase encoding 0 decode .. 3 write.
module idx_exec_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          phase_strobe,
    input logic [1:0]    phase,
    input logic          mem_rd_en,
    input logic          mem_wr_en,
    input logic          illegal,
    input logic [DW-1:0] acc,
    input logic [4:0]    flags
);
    // R10
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));
    // R10
    wr_in_wphase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (phase == 2'd3 && phase_strobe));
    // R10
    rd_in_rphase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (phase == 2'd1 && phase_strobe));
    // R8
    illegal_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!mem_wr_en && !mem_rd_en));
    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_strobe |=> phase == 2'($past(phase) + 2'd1));
    // R2
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_strobe |=> $stable(phase));
    // R5
    flags_only_at_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(phase_strobe && phase == 2'd3) |=> $stable(flags));
    // R4
    acc_only_at_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(phase_strobe && phase == 2'd3) |=> $stable(acc));
endmodule

bind idx_exec_unit idx_exec_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .phase_strobe (phase_strobe),
    .phase        (phase),
    .mem_rd_en    (mem_rd_en),
    .mem_wr_en    (mem_wr_en),
    .illegal      (illegal),
    .acc          (acc),
    .flags        (flags)
);

// File: tb/idx_exec_unit_test.sv
module idx_exec_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phase_strobe = 1'b0;
    logic [15:0] instr = '0;
    logic [11:0] ptr = '0;
    logic [11:0] mem_addr;
    logic        mem_rd_en, mem_wr_en;
    logic [7:0]  mem_rdata = '0;
    logic [7:0]  mem_wdata, acc;
    logic [4:0]  flags;
    logic        illegal;
    logic [1:0]  phase;

    int total = 0, bad = 0;
    int rd_cnt = 0, wr_cnt = 0;
    logic [11:0] rd_addr = '0;
    logic [7:0]  mem [0:4095];
    logic [7:0]  acc_m = '0;
    logic [4:0]  flg_m = '0;
    bit          done = 0;

    always #4 clk = ~clk;

    idx_exec_unit uut (
        .clk(clk), .rst_n(rst_n), .phase_strobe(phase_strobe),
        .instr(instr), .ptr(ptr), .mem_addr(mem_addr),
        .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
        .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata),
        .acc(acc), .flags(flags), .illegal(illegal), .phase(phase)
    );

    // Synchronous memory model with access monitors.
    always @(posedge clk) begin
        if (mem_wr_en) begin
            mem[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (mem_rd_en) begin
            mem_rdata <= mem[mem_addr];
            rd_addr   <= mem_addr;
            rd_cnt    <= rd_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Runs one instruction through four strobes and checks every visible effect.
    task automatic exec(input logic [15:0] iw, input logic [11:0] p, input int gap);
        logic [7:0] k, oldm, e_mem, e_acc, r;
        logic [4:0] e_flg;
        int ea, s, rd0, wr0, e_wr, e_rd;
        bit is_add, is_bset, is_fill, known, legal, e_ill;
        string tag;
        k       = iw[7:0];
        ea      = (int'(p) + int'(k)) % 4096;
        is_add  = (iw[15:10] == 6'b001001) && !iw[8];
        is_bset = (iw[15:12] == 4'b1000) && !iw[8];
        is_fill = (iw[15:8] == 8'h68);
        known   = is_add || is_bset || is_fill;
        legal   = (k <= 8'd95);
        e_ill   = known && !legal;
        oldm    = mem[ea];
        e_mem = oldm; e_acc = acc_m; e_flg = flg_m; e_wr = 0; e_rd = 0;
        tag = !known ? "R9" : !legal ? "R8" : is_add ? "R4" : is_bset ? "R6" : "R7";
        if (known && legal) begin
            e_rd = 1;
            if (is_add) begin
                s = int'(acc_m) + int'(oldm);
                r = 8'(s % 256);
                e_flg[4] = r[7];
                e_flg[3] = (acc_m[7] == oldm[7]) && (r[7] != acc_m[7]);
                e_flg[2] = (r == 8'h00);
                e_flg[1] = ((int'(acc_m) % 16) + (int'(oldm) % 16)) > 15;
                e_flg[0] = s > 255;
                if (iw[9]) begin e_mem = r; e_wr = 1; end
                else e_acc = r;
            end else if (is_bset) begin
                e_mem = oldm | 8'(1 << iw[11:9]);
                e_wr = 1;
            end else begin
                e_mem = 8'hFF;
                e_wr = 1;
            end
        end
        rd0 = rd_cnt; wr0 = wr_cnt;
        instr = iw; ptr = p;
        for (int ph = 0; ph < 4; ph++) begin
            if (gap > 0) begin
                repeat (gap) @(negedge clk);
                check(phase == 2'(ph), "R2 hold", phase, ph);
            end
            phase_strobe = 1'b1;
            @(negedge clk);
            phase_strobe = 1'b0;
            check(phase == 2'((ph + 1) % 4), "R2 step", phase, (ph + 1) % 4);
        end
        check(mem[ea] == e_mem, tag, mem[ea], e_mem);
        check(acc == e_acc, is_add ? "R4 acc" : "R6/R7 acc", acc, e_acc);
        check(flags == e_flg, "R5 flags", flags, e_flg);
        check(illegal == e_ill, "R8 illegal", illegal, e_ill);
        check(wr_cnt - wr0 == e_wr, "R10 writes", wr_cnt - wr0, e_wr);
        check(rd_cnt - rd0 == e_rd, "R9 reads", rd_cnt - rd0, e_rd);
        if (e_rd != 0) check(rd_addr == 12'(ea), "R3 addr", rd_addr, ea);
        acc_m = e_acc;
        flg_m = e_flg;
    endtask

    // Steers the accumulator to a target through a d=0 add on a scratch byte.
    task automatic set_acc(input logic [7:0] target, input int gap);
        mem[12'h100] = target - acc_m;
        exec(16'h2400, 12'h100, gap);
    endtask

    function automatic logic [7:0] corner(input int i);
        logic [7:0] v [16] = '{8'h00, 8'h01, 8'h07, 8'h08, 8'h0F, 8'h10, 8'h3F, 8'h40,
                               8'h7F, 8'h80, 8'h81, 8'hC0, 8'hEF, 8'hF0, 8'hFE, 8'hFF};
        return v[i];
    endfunction

    initial begin
        #(8 * 190000);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        // R1 values held during reset
        check(acc == 8'h00, "R1 acc", acc, 0);
        check(flags == 5'd0, "R1 flags", flags, 0);
        check(phase == 2'd0, "R1 phase", phase, 0);
        check(!mem_rd_en && !mem_wr_en, "R1 enables", {mem_rd_en, mem_wr_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(phase == 2'd0 && acc == 8'h00, "R1 after release", phase, 0);

        // Worked examples: add to memory and bit set on bit 7.
        set_acc(8'h17, 0);
        mem[12'hA2C] = 8'h20;
        exec(16'h262C, 12'hA00, 0);
        check(mem[12'hA2C] == 8'h37, "R4 example", mem[12'hA2C], 8'h37);
        mem[12'hA0A] = 8'h55;
        exec(16'h8E0A, 12'hA00, 1);
        check(mem[12'hA0A] == 8'hD5, "R6 example", mem[12'hA0A], 8'hD5);

        // R4 R5 R11: corner-value grid for both destinations, with strobe gaps.
        for (int a = 0; a < 16; a++) begin
            for (int m = 0; m < 16; m++) begin
                for (int d = 0; d < 2; d++) begin
                    set_acc(corner(a), 0);
                    mem[12'hA00 + 12'(m)] = corner(m);
                    exec(16'h2400 | 16'(d << 9) | 16'(m), 12'hA00, (a + m) % 3);
                end
            end
        end

        // R6: every bit index against several bytes and offsets.
        for (int b = 0; b < 8; b++) begin
            for (int j = 0; j < 4; j++) begin
                mem[12'h500 + 12'(j * 31)] = corner(j * 5);
                exec(16'h8000 | 16'(b << 9) | 16'(j * 31), 12'h500, j);
            end
        end

        // R7: fill over the offset range, including 95.
        for (int k = 0; k <= 95; k += 19) exec(16'h6800 | 16'(k), 12'h300, 0);
        exec(16'h685F, 12'h300, 2);

        // R3: wrap past the top of the address space.
        mem[12'h05E] = 8'h11;
        exec(16'h685F, 12'hFFF, 0);
        mem[12'h000] = 8'h20;
        exec(16'h8001, 12'hFFF, 0);
        set_acc(8'h40, 0);
        mem[12'h01F] = 8'h05;
        exec(16'h2640, 12'hFDF, 0);

        // R8: every out-of-range offset for all three operations.
        for (int k = 96; k < 256; k++) begin
            exec(16'h2600 | 16'(k), 12'h700, 0);
            exec(16'h8600 | 16'(k), 12'h700, 0);
            exec(16'h6800 | 16'(k), 12'h700, k % 2);
        end
        exec(16'h2405, 12'h700, 0);
        check(illegal == 1'b0, "R8 clears", illegal, 0);

        // R9: words outside the three encodings.
        exec(16'h2505, 12'h700, 0);
        exec(16'h8105, 12'h700, 0);
        exec(16'h6905, 12'h700, 0);
        exec(16'h0000, 12'h700, 0);
        exec(16'hFFFF, 12'h700, 1);
        exec(16'h2205, 12'h700, 0);

        summary();
    end
endmodule